// File: doc/BRIEF.md
# Earliest Bank Preparation Evaluator

This block looks at the timing state of every bank in a memory channel and picks the banks that should get the next row activate. For each bank it takes a flag for open or closed, the earliest permitted activate, precharge and column times, and a flag that says whether any queued request targets that bank. It also takes the current time, the column deadline that would keep the data bus busy with no gap, and the precharge and activate-to-column delays. A bank whose column command can meet the deadline is preferred over banks that merely activate soonest. The result is a mask with one bit per bank and a flag that says whether the chosen activate can be hidden behind the data transfers already in flight.

The evaluation is a registered sweep that visits one bank per clock, rank by rank and bank by bank within each rank. A one-cycle start pulse while idle launches a sweep. The mask and flag are final when the done pulse appears, and they hold until the next sweep is launched. The inputs must stay stable from the start pulse until done.

Top module: `bprep_eval`

## Requirements
- R1: After a synchronous active-low reset, busy, done, bank_mask and hidden_prep are all 0.
- R2: A start pulse sampled while idle raises busy on the next edge. done is high for exactly one cycle, NB clock edges after the edge that sampled start (NB = NUM_RANKS × BANKS_PER_RANK), and busy is low from that same edge.
- R3: A start pulse sampled while busy is ignored. The running sweep finishes on its original schedule with its original result, and no extra done follows.
- R4: A bank whose pending bit is 0 never appears in bank_mask. When no bank is pending, the sweep ends with bank_mask = 0 and hidden_prep = 0.
- R5: The activate time of a closed bank is max(activate-allowed, now). For an open bank it is max(precharge-allowed, now) + tRP. All sums are formed at full precision with no wrap-around.
- R6: A bank is seamless when max(column-allowed, activate time + tRCD) ≤ the column deadline. Equality counts.
- R7: The hidden limit is max(deadline − tRCD, now). When tRCD exceeds the deadline, the limit is now.
- R8: The visit keeps a running best activate time, which starts at the all-ones maximum, and a found-seamless flag. A pending bank is added if it is seamless, or if no seamless bank has been found and its activate time is ≤ the best. Before the bank is added, the mask is cleared when no seamless bank had been found and the bank is either seamless or strictly earlier than the best. Each added bank replaces the best with its own activate time.
- R9: hidden_prep is the outcome for the last bank added to the mask: 1 when that bank's activate time is ≤ the hidden limit.
- R10: Bit rank × BANKS_PER_RANK + bank of bank_mask stands for that bank. The same index selects the bank's pending bit, open bit and time field (field i of a flat vector occupies bits i×TIME_W upward). Banks are visited in ascending index order.
- R11: At done, bank_mask is nonzero exactly when at least one pending bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch a sweep when idle |
| now_time | input | TIME_W | Current time |
| col_deadline | input | TIME_W | Latest column time that keeps the bus seamless |
| t_rp | input | TIME_W | Precharge delay |
| t_rcd | input | TIME_W | Activate-to-column delay |
| bank_open | input | NB | 1 = bank has an open row |
| pending | input | NB | 1 = a queued request targets the bank |
| act_ok_at | input | NB×TIME_W | Per-bank activate-allowed time |
| pre_ok_at | input | NB×TIME_W | Per-bank precharge-allowed time |
| col_ok_at | input | NB×TIME_W | Per-bank column-allowed time |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse when the result is final |
| bank_mask | output | NB | Preferred banks |
| hidden_prep | output | 1 | Chosen activate can be hidden |

## Verification
The bench goes after ties and strict-less-than clearing. If ≤ and < were swapped, a design would either drop a tied bank or keep a stale later one. It builds cases where a seamless bank arrives after a strictly earlier non-seamless bank, which a design without seamless priority would miss. It also places a column time exactly on the deadline, which a strict comparison would reject. It drives tRCD above the deadline: a design that wrapped the subtraction would report hidden_prep for a late activate. It drives times near the top of the range: a design that truncated the sums would wrap and pick the wrong bank. Several hundred pseudo-random scenarios with small time values produce dense ties, and an arithmetic model in the bench predicts each mask and flag.

// File: rtl/bprep_pkg.sv
// Package: shared types for the bank preparation evaluator.
// Assumes nothing beyond IEEE 1800-2017 packages.
package bprep_pkg;

    // Sweep controller states
    typedef enum logic {
        SW_IDLE  = 1'b0,
        SW_SCAN  = 1'b1
    } sweep_state_e;

endpackage

// File: rtl/bprep_timing.sv
// Module: bprep_timing
// Purpose: per-bank combinational timing arithmetic. Derives the bank's
// activate time, whether its column command meets the seamless deadline,
// and whether its activate lies at or before the hidden limit.
// Assumes: EXT_W >= TIME_W + 2 so sums of two TIME_W values never wrap.
module bprep_timing #(
    parameter int TIME_W = 12,
    parameter int EXT_W  = TIME_W + 2
) (
    input  logic              is_open,
    input  logic [TIME_W-1:0] act_ok,
    input  logic [TIME_W-1:0] pre_ok,
    input  logic [TIME_W-1:0] col_ok,
    input  logic [TIME_W-1:0] now_time,
    input  logic [TIME_W-1:0] col_deadline,
    input  logic [TIME_W-1:0] t_rp,
    input  logic [TIME_W-1:0] t_rcd,
    output logic [EXT_W-1:0]  act_at,
    output logic              seamless,
    output logic              hidden_ok
);

    logic [EXT_W-1:0] now_x, dl_x, rp_x, rcd_x;
    logic [EXT_W-1:0] act_x, pre_x, colok_x;
    logic [EXT_W-1:0] col_at, hid_lim, dl_minus;

    // Widen all operands so arithmetic is exact
    always_comb begin
        now_x   = EXT_W'(now_time);
        dl_x    = EXT_W'(col_deadline);
        rp_x    = EXT_W'(t_rp);
        rcd_x   = EXT_W'(t_rcd);
        act_x   = EXT_W'(act_ok);
        pre_x   = EXT_W'(pre_ok);
        colok_x = EXT_W'(col_ok);
    end

    // Activate time: closed banks wait on activate-allowed, open ones precharge first
    always_comb begin
        if (is_open)
            act_at = ((pre_x > now_x) ? pre_x : now_x) + rp_x;
        else
            act_at = (act_x > now_x) ? act_x : now_x;
    end

    // Earliest column time and the seamless test against the deadline
    always_comb begin
        col_at   = ((act_at + rcd_x) > colok_x) ? (act_at + rcd_x) : colok_x;
        seamless = (col_at <= dl_x);
    end

    // Hidden limit with clamp when tRCD exceeds the deadline
    always_comb begin
        dl_minus  = (dl_x >= rcd_x) ? (dl_x - rcd_x) : '0;
        hid_lim   = (dl_minus > now_x) ? dl_minus : now_x;
        hidden_ok = (act_at <= hid_lim);
    end

endmodule

// File: rtl/bprep_sweep.sv
// Module: bprep_sweep
// Purpose: sequences a one-bank-per-cycle visit over NB banks. A start
// pulse while idle launches a scan; starts during a scan are ignored.
// done pulses for one cycle after the last bank has been stepped.
// Assumes NB >= 2.
module bprep_sweep
    import bprep_pkg::*;
#(
    parameter int NB    = 8,
    parameter int IDX_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             launch,
    output logic             step,
    output logic [IDX_W-1:0] idx,
    output logic             busy,
    output logic             done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NB - 1);

    sweep_state_e state;
    logic         at_last;

    // Decode launch, step and last-bank from the current state
    always_comb begin
        launch  = (state == SW_IDLE) && start;
        step    = (state == SW_SCAN);
        at_last = step && (idx == LAST_IDX);
        busy    = step;
    end

    // State, bank index and done pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SW_IDLE;
            idx   <= '0;
            done  <= 1'b0;
        end else begin
            done <= at_last;
            if (launch) begin
                state <= SW_SCAN;
                idx   <= '0;
            end else if (at_last) begin
                state <= SW_IDLE;
                idx   <= '0;
            end else if (step) begin
                idx <= idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/bprep_accum.sv
// Module: bprep_accum
// Purpose: holds the running mask, best activate time, found-seamless flag
// and hidden flag, updating them with the one bank stepped each cycle.
// Assumes launch and step are never high together.
module bprep_accum #(
    parameter int NB    = 8,
    parameter int EXT_W = 14,
    parameter int IDX_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             step,
    input  logic [IDX_W-1:0] idx,
    input  logic             cur_pending,
    input  logic [EXT_W-1:0] cur_act_at,
    input  logic             cur_seamless,
    input  logic             cur_hidden_ok,
    output logic [NB-1:0]    mask,
    output logic             hidden
);

    logic [EXT_W-1:0] best;
    logic             found;
    logic             joins, wipes;
    logic [NB-1:0]    sel_bit;

    // Decide whether the current bank joins and whether it wipes the mask
    always_comb begin
        joins   = step && cur_pending &&
                  (cur_seamless || (!found && (cur_act_at <= best)));
        wipes   = !found && (cur_seamless || (cur_act_at < best));
        sel_bit = NB'(1) << idx;
    end

    // Accumulator registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask   <= '0;
            best   <= '1;
            found  <= 1'b0;
            hidden <= 1'b0;
        end else if (launch) begin
            mask   <= '0;
            best   <= '1;
            found  <= 1'b0;
            hidden <= 1'b0;
        end else if (joins) begin
            mask   <= (wipes ? '0 : mask) | sel_bit;
            best   <= cur_act_at;
            found  <= found | cur_seamless;
            hidden <= cur_hidden_ok;
        end
    end

endmodule

// File: rtl/bprep_eval.sv
// Module: bprep_eval (top)
// Purpose: earliest bank preparation evaluator. Sweeps all banks of all
// ranks, one per cycle, and returns the preferred-activate mask plus a
// flag telling whether the chosen activate can stay hidden.
// Assumes all data inputs stay stable from the start pulse until done.
module bprep_eval #(
    parameter int NUM_RANKS      = 2,
    parameter int BANKS_PER_RANK = 4,
    parameter int TIME_W         = 12,
    parameter int NB             = NUM_RANKS * BANKS_PER_RANK
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [TIME_W-1:0]    now_time,
    input  logic [TIME_W-1:0]    col_deadline,
    input  logic [TIME_W-1:0]    t_rp,
    input  logic [TIME_W-1:0]    t_rcd,
    input  logic [NB-1:0]        bank_open,
    input  logic [NB-1:0]        pending,
    input  logic [NB*TIME_W-1:0] act_ok_at,
    input  logic [NB*TIME_W-1:0] pre_ok_at,
    input  logic [NB*TIME_W-1:0] col_ok_at,
    output logic                 busy,
    output logic                 done,
    output logic [NB-1:0]        bank_mask,
    output logic                 hidden_prep
);

    localparam int EXT_W = TIME_W + 2;
    localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;

    logic [TIME_W-1:0] act_f [NB];
    logic [TIME_W-1:0] pre_f [NB];
    logic [TIME_W-1:0] col_f [NB];

    // Unpack per-bank fields rank by rank; flat index = rank*BPR + bank
    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        for (genvar b = 0; b < BANKS_PER_RANK; b++) begin : g_bank
            localparam int FI = r * BANKS_PER_RANK + b;
            assign act_f[FI] = act_ok_at[FI*TIME_W +: TIME_W];
            assign pre_f[FI] = pre_ok_at[FI*TIME_W +: TIME_W];
            assign col_f[FI] = col_ok_at[FI*TIME_W +: TIME_W];
        end
    end

    logic             launch, step;
    logic [IDX_W-1:0] idx;

    bprep_sweep #(.NB(NB), .IDX_W(IDX_W)) sweep_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .launch (launch),
        .step   (step),
        .idx    (idx),
        .busy   (busy),
        .done   (done)
    );

    logic              cur_open, cur_pend;
    logic [TIME_W-1:0] cur_act, cur_pre, cur_col;

    // Select the state of the bank being visited this cycle
    always_comb begin
        cur_open = bank_open[idx];
        cur_pend = pending[idx];
        cur_act  = act_f[idx];
        cur_pre  = pre_f[idx];
        cur_col  = col_f[idx];
    end

    logic [EXT_W-1:0] cur_act_at;
    logic             cur_seamless, cur_hidden_ok;

    bprep_timing #(.TIME_W(TIME_W), .EXT_W(EXT_W)) timing_i (
        .is_open      (cur_open),
        .act_ok       (cur_act),
        .pre_ok       (cur_pre),
        .col_ok       (cur_col),
        .now_time     (now_time),
        .col_deadline (col_deadline),
        .t_rp         (t_rp),
        .t_rcd        (t_rcd),
        .act_at       (cur_act_at),
        .seamless     (cur_seamless),
        .hidden_ok    (cur_hidden_ok)
    );

    bprep_accum #(.NB(NB), .EXT_W(EXT_W), .IDX_W(IDX_W)) accum_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .launch        (launch),
        .step          (step),
        .idx           (idx),
        .cur_pending   (cur_pend),
        .cur_act_at    (cur_act_at),
        .cur_seamless  (cur_seamless),
        .cur_hidden_ok (cur_hidden_ok),
        .mask          (bank_mask),
        .hidden        (hidden_prep)
    );

endmodule

// File: rtl/bprep_eval_chk.sv
// Module: bprep_eval_chk
// Purpose: protocol and result checks on the evaluator ports, bound to
// every bprep_eval instance. Counts scan cycles to check the done timing.
module bprep_eval_chk #(
    parameter int NB = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [NB-1:0] pending,
    input logic          busy,
    input logic          done,
    input logic [NB-1:0] bank_mask,
    input logic          hidden_prep
);

    logic [15:0] scan_cnt;

    // Count scan cycles since the accepted start
    always_ff @(posedge clk) begin
        if (!rst_n)
            scan_cnt <= '0;
        else if (start && !busy)
            scan_cnt <= '0;
        else if (busy)
            scan_cnt <= scan_cnt + 16'd1;
    end

    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R3: a start during the scan must not shift the done edge
    a_r3_done_after_nb: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (scan_cnt == 16'(NB)));

    a_r4_mask_in_pending: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((bank_mask & ~pending) == '0));

    a_r11_mask_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((bank_mask != '0) == (pending != '0)));

    a_r9_hidden_needs_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (done && hidden_prep) |-> (bank_mask != '0));

endmodule

bind bprep_eval bprep_eval_chk #(.NB(NB)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .pending     (pending),
    .busy        (busy),
    .done        (done),
    .bank_mask   (bank_mask),
    .hidden_prep (hidden_prep)
);

// File: tb/bprep_eval_tb_top.sv
// Bench for bprep_eval: directed corner cases plus a pseudo-random sweep,
// with expected mask and flag computed arithmetically from the requirements.
module bprep_eval_tb_top;

    localparam int NR = 2;
    localparam int BPR = 4;
    localparam int TW = 12;
    localparam int NB = NR * BPR;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [TW-1:0] now_time = '0, col_deadline = '0, t_rp = '0, t_rcd = '0;
    logic [NB-1:0] bank_open = '0, pending = '0;
    logic [NB*TW-1:0] act_flat, pre_flat, col_flat;
    logic busy, done, hidden_prep;
    logic [NB-1:0] bank_mask;

    logic [TW-1:0] a_act [NB];
    logic [TW-1:0] a_pre [NB];
    logic [TW-1:0] a_col [NB];

    always #10 clk = ~clk;

    // Pack per-bank arrays into flat port vectors
    always_comb begin
        for (int i = 0; i < NB; i++) begin
            act_flat[i*TW +: TW] = a_act[i];
            pre_flat[i*TW +: TW] = a_pre[i];
            col_flat[i*TW +: TW] = a_col[i];
        end
    end

    bprep_eval #(.NUM_RANKS(NR), .BANKS_PER_RANK(BPR), .TIME_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .now_time(now_time), .col_deadline(col_deadline),
        .t_rp(t_rp), .t_rcd(t_rcd),
        .bank_open(bank_open), .pending(pending),
        .act_ok_at(act_flat), .pre_ok_at(pre_flat), .col_ok_at(col_flat),
        .busy(busy), .done(done), .bank_mask(bank_mask), .hidden_prep(hidden_prep)
    );

    int n_chk = 0;
    int n_err = 0;
    logic [NB-1:0] exp_mask;
    logic exp_hidden;
    logic [31:0] rng = 32'h1234_5678;

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // Arithmetic model of the requirements R4-R10
    task automatic model();
        longint best, lim, act, col, dl;
        bit found;
        best = (64'd1 << (TW + 2)) - 1;
        found = 0;
        exp_mask = '0;
        exp_hidden = 1'b0;
        dl = longint'(col_deadline);
        lim = (dl >= longint'(t_rcd)) ? dl - longint'(t_rcd) : 0;
        if (lim < longint'(now_time)) lim = longint'(now_time);
        for (int i = 0; i < NB; i++) begin
            if (pending[i]) begin
                if (bank_open[i])
                    act = ((a_pre[i] > now_time) ? longint'(a_pre[i]) : longint'(now_time)) + longint'(t_rp);
                else
                    act = (a_act[i] > now_time) ? longint'(a_act[i]) : longint'(now_time);
                col = act + longint'(t_rcd);
                if (longint'(a_col[i]) > col) col = longint'(a_col[i]);
                if ((col <= dl) || (!found && act <= best)) begin
                    if (!found && ((col <= dl) || act < best)) exp_mask = '0;
                    if (col <= dl) found = 1;
                    exp_hidden = (act <= lim);
                    exp_mask[i] = 1'b1;
                    best = act;
                end
            end
        end
    endtask

    task automatic clear_all();
        for (int i = 0; i < NB; i++) begin
            a_act[i] = '0; a_pre[i] = '0; a_col[i] = '0;
        end
        bank_open = '0; pending = '0;
        now_time = '0; col_deadline = '0; t_rp = '0; t_rcd = '0;
    endtask

    // Launch a sweep; returns cycles from the start-sampling edge to done
    task automatic run(input bit extra_start, output int lat);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 3 * NB) begin
            start = (extra_start && lat == 2);
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
    endtask

    task automatic run_and_check(input string tag, input bit extra_start);
        int lat;
        model();
        run(extra_start, lat);
        chk({tag, " R2 latency"}, lat, NB);
        chk({tag, " mask"}, bank_mask, exp_mask);
        chk({tag, " hidden"}, hidden_prep, exp_hidden);
        @(negedge clk);
        chk({tag, " R2 done one cycle"}, done, 0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int extra_done;
        clear_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 mask", bank_mask, 0);
        chk("R1 hidden", hidden_prep, 0);

        // R4: nothing pending
        clear_all();
        now_time = 12'd3; col_deadline = 12'd40;
        run_and_check("R4 none pending", 0);
        chk("R4 mask zero", bank_mask, 0);

        // R5: open bank pays tRP; closed later bank strictly earlier wins
        clear_all();
        now_time = 12'd5; t_rp = 12'd3; t_rcd = 12'd2;
        bank_open[0] = 1'b1; a_pre[0] = 12'd10; a_act[1] = 12'd12;
        pending = 8'b0000_0011;
        run_and_check("R5 open vs closed", 0);
        chk("R5 mask", bank_mask, 8'b0000_0010);

        // R6: seamless bank beats an earlier non-seamless one
        clear_all();
        t_rcd = 12'd2; col_deadline = 12'd20;
        a_act[0] = 12'd1; a_col[3] = 12'd25;
        pending = 8'b0000_1001;
        run_and_check("R6 seamless priority", 0);
        chk("R6 mask", bank_mask, 8'b0000_0001);
        chk("R9 hidden", hidden_prep, 1);

        // R6: column exactly on the deadline counts as seamless; R8 clear
        clear_all();
        t_rcd = 12'd2; col_deadline = 12'd6;
        a_col[2] = 12'd9; a_act[5] = 12'd4;
        pending = 8'b0010_0100;
        run_and_check("R6 deadline equal", 0);
        chk("R8 mask", bank_mask, 8'b0010_0000);

        // R7: tRCD above the deadline clamps the hidden limit to now
        clear_all();
        now_time = 12'd10; col_deadline = 12'd3; t_rcd = 12'd5;
        a_act[4] = 12'd12;
        pending = 8'b0001_0000;
        run_and_check("R7 underflow", 0);
        chk("R7 hidden", hidden_prep, 0);

        // R10: rank 1 bank 2 is bit 6; ties join together (R8)
        clear_all();
        now_time = 12'd7; a_act[1] = 12'd9; a_act[6] = 12'd9;
        pending = 8'b0100_0010;
        run_and_check("R10 index and tie", 0);
        chk("R10 mask", bank_mask, 8'b0100_0010);

        // R5: values near the top of the range must not wrap
        clear_all();
        now_time = 12'd4000; t_rp = 12'd4095; t_rcd = 12'd4095;
        col_deadline = 12'd4095;
        bank_open[0] = 1'b1; a_pre[0] = 12'd4095; a_act[7] = 12'd4090;
        pending = 8'b1000_0001;
        run_and_check("R5 no wrap", 0);
        chk("R5 wide mask", bank_mask, 8'b1000_0000);

        // R3: start during a sweep is ignored
        clear_all();
        now_time = 12'd2; a_act[3] = 12'd6; a_act[2] = 12'd8;
        pending = 8'b0000_1100;
        run_and_check("R3 extra start", 1);
        extra_done = 0;
        for (int k = 0; k < NB + 2; k++) begin
            @(negedge clk);
            if (done) extra_done++;
        end
        chk("R3 no extra done", extra_done, 0);
        chk("R3 mask", bank_mask, 8'b0000_1000);

        // R8/R9/R11: pseudo-random scenarios with dense ties
        for (int s = 0; s < 400; s++) begin
            clear_all();
            rng = nxt(rng); now_time = TW'(rng[4:0]);
            col_deadline = TW'(rng[10:5] % 48);
            t_rp = TW'(rng[13:11]); t_rcd = TW'(rng[16:14]);
            bank_open = rng[24:17];
            rng = nxt(rng); pending = rng[7:0];
            for (int i = 0; i < NB; i++) begin
                rng = nxt(rng);
                a_act[i] = TW'(rng[4:0]);
                a_pre[i] = TW'(rng[9:5]);
                a_col[i] = TW'(rng[15:10] % 40);
            end
            run_and_check("R8 R9 random", 0);
            chk("R11 nonempty", (bank_mask != 0), (pending != 0));
        end

        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule